// File: doc/BRIEF.md
# Dual-Rate LED Dimming Engine

This block drives eight open-drain LED pins from two shared dimming waveforms. Each waveform has an 8-bit period prescaler and an 8-bit duty value. A 2-bit mode field per pin places that pin in one of four states: released, steadily pulled low, following the first waveform, or following the second. The host sets a rate once and then writes a single mode change per LED event. Nothing else on the bus has to be refreshed.

Each waveform has an 8-bit phase counter. The counter advances once every PSC+1 pulses of a time-base enable, and that enable runs at 256 times the 160 Hz base rate. One phase wrap is therefore one dim period of (PSC+1)/160 s. New prescaler and duty values are copied into working copies only when the phase wraps, so a period is never cut short or stretched part way through.

The engine also samples the eight pin levels through a two-flop synchronizer, so pins that are not used for LEDs can be read as general-purpose inputs.

Top module: `led_dim_engine`

## Requirements
- R1: While `rst_n` is low, `drive_en`, `pull_low` and `pin_byte` are all zero.
- R2: A dim waveform is active (LED on) while its phase count is below its working duty value. The phase count starts at 0 and advances by one, wrapping from 255 to 0, once every (working prescaler + 1) cycles in which `tick` is high.
- R3: When the working duty value is 0x00, the waveform never turns its LEDs on.
- R4: The working prescaler and duty values load from `psc*_in`/`pwm*_in` only on the tick that wraps the phase from 255 to 0. They hold at all other times.
- R5: The mode code for each pin sets its drive as follows:
  - 0 releases it (`drive_en`=0, `pull_low`=0).
  - 1 pulls it low (`drive_en`=1, `pull_low`=1).
  - 2 follows waveform 0 and 3 follows waveform 1 (`drive_en`=1, `pull_low` = waveform active).
- R6: `sel_lo` bits [2k+1:2k] select the mode of pin k for k = 0..3. `sel_hi` bits [2k+1:2k] select the mode of pin k+4.
- R7: `drive_en` and `pull_low` are registered. After each rising edge they reflect the mode inputs and waveform states sampled at that edge.
- R8: `pin_byte` bit n equals `pin_level` bit n as sampled two rising edges earlier.
- R9: The two waveforms run independently, each from its own prescaler and duty value.
- R10: After reset the working prescalers are 0x00 and the working duty values are 0x80, both phase counts are 0, and these values govern the first period.
- R11: In a cycle where `tick` is low, both waveform states and phase counts keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle time-base enable (256 x 160 Hz) |
| psc0_in | input | 8 | Period prescaler for waveform 0 |
| pwm0_in | input | 8 | Duty value for waveform 0 |
| psc1_in | input | 8 | Period prescaler for waveform 1 |
| pwm1_in | input | 8 | Duty value for waveform 1 |
| sel_lo | input | 8 | Mode fields for pins 0 to 3 |
| sel_hi | input | 8 | Mode fields for pins 4 to 7 |
| pin_level | input | 8 | Sampled logic level of each LED pin |
| drive_en | output | 8 | Per-pin output enable (0 = high impedance) |
| pull_low | output | 8 | Per-pin pull-low command |
| pin_byte | output | 8 | Synchronized pin levels |

## Verification
The engine is driven in several regimes, and each one separates a different class of fault:
- **First period after reset.** The inputs carry values other than the defaults, which exposes wrong reset values or loading a new value too early.
- **Random duty values changing every cycle.** This catches any load of the working values before the wrap.
- **Duty 0x00 against 0xFF.** These expose off-by-one errors in the phase comparison.
- **Long stretches with no tick.** These show whether the counters hold their values.
- **Unequal prescalers on the two waveforms.** This catches crossed or shared channels.
- **Mode fields randomized every cycle.** This separates field decoding, byte placement and output latency.

A cycle-accurate model in the bench predicts every pin on every cycle.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ON   = 2'b01,
        MODE_DIM0 = 2'b10,
        MODE_DIM1 = 2'b11
    } led_mode_e;

    localparam int unsigned DIM_CHANNELS = 2;
    localparam int unsigned MODE_W       = 2;

endpackage

// File: rtl/dim_channel.sv
module dim_channel #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] psc_in,
    input  logic [CNT_W-1:0] pwm_in,
    output logic             dim_on,
    output logic             wrap,
    output logic [CNT_W-1:0] pwm_cur
);

    typedef struct packed {
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] phase;
        logic [CNT_W-1:0] psc;
        logic [CNT_W-1:0] pwm;
    } chan_t;

    localparam logic [CNT_W-1:0] PWM_RESET = {1'b1, {(CNT_W-1){1'b0}}};

    chan_t chan_d, chan_q;
    logic  step;

    always_comb begin
        chan_d = chan_q;
        step   = tick && (chan_q.pre == chan_q.psc);
        wrap   = step && (chan_q.phase == '1);
        if (tick) begin
            if (step) begin
                chan_d.pre   = '0;
                chan_d.phase = chan_q.phase + 1'b1;
                if (wrap) begin
                    chan_d.psc = psc_in;
                    chan_d.pwm = pwm_in;
                end
            end else begin
                chan_d.pre = chan_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q.pre   <= '0;
            chan_q.phase <= '0;
            chan_q.psc   <= '0;
            chan_q.pwm   <= PWM_RESET;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign dim_on  = chan_q.phase < chan_q.pwm;
    assign pwm_cur = chan_q.pwm;

endmodule

// File: rtl/led_drive_sel.sv
module led_drive_sel
    import led_dim_pkg::*;
(
    input  logic [MODE_W-1:0]       mode,
    input  logic [DIM_CHANNELS-1:0] dim_on,
    output logic                    oe,
    output logic                    pull
);

    led_mode_e mode_e;

    always_comb begin
        mode_e = led_mode_e'(mode);
        oe     = 1'b1;
        pull   = 1'b0;
        unique case (mode_e)
            MODE_OFF:  oe   = 1'b0;
            MODE_ON:   pull = 1'b1;
            MODE_DIM0: pull = dim_on[0];
            MODE_DIM1: pull = dim_on[1];
        endcase
    end

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/led_dim_engine.sv
module led_dim_engine
    import led_dim_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 8,
    parameter int unsigned CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [CNT_W-1:0]    psc0_in,
    input  logic [CNT_W-1:0]    pwm0_in,
    input  logic [CNT_W-1:0]    psc1_in,
    input  logic [CNT_W-1:0]    pwm1_in,
    input  logic [NUM_LEDS-1:0] sel_lo,
    input  logic [NUM_LEDS-1:0] sel_hi,
    input  logic [NUM_LEDS-1:0] pin_level,
    output logic [NUM_LEDS-1:0] drive_en,
    output logic [NUM_LEDS-1:0] pull_low,
    output logic [NUM_LEDS-1:0] pin_byte
);

    localparam int unsigned SEL_W = MODE_W * NUM_LEDS;

    typedef struct packed {
        logic [NUM_LEDS-1:0] oe;
        logic [NUM_LEDS-1:0] pull;
    } drv_t;

    logic [SEL_W-1:0]                   sel_all;
    logic [DIM_CHANNELS-1:0]            dim_on;
    logic [DIM_CHANNELS-1:0]            wrap_ev;
    logic [DIM_CHANNELS-1:0][CNT_W-1:0] pwm_cur;
    logic [DIM_CHANNELS-1:0][CNT_W-1:0] psc_vec;
    logic [DIM_CHANNELS-1:0][CNT_W-1:0] pwm_vec;
    logic [NUM_LEDS-1:0]                oe_c, pull_c;
    drv_t                               drv_d, drv_q;

    assign sel_all = {sel_hi, sel_lo};
    assign psc_vec = {psc1_in, psc0_in};
    assign pwm_vec = {pwm1_in, pwm0_in};

    for (genvar c = 0; c < DIM_CHANNELS; c++) begin : g_chan
        dim_channel #(.CNT_W(CNT_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .psc_in  (psc_vec[c]),
            .pwm_in  (pwm_vec[c]),
            .dim_on  (dim_on[c]),
            .wrap    (wrap_ev[c]),
            .pwm_cur (pwm_cur[c])
        );
    end

    for (genvar n = 0; n < NUM_LEDS; n++) begin : g_led
        led_drive_sel i_sel (
            .mode   (sel_all[MODE_W*n +: MODE_W]),
            .dim_on (dim_on),
            .oe     (oe_c[n]),
            .pull   (pull_c[n])
        );
    end

    always_comb begin
        drv_d.oe   = oe_c;
        drv_d.pull = pull_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign drive_en = drv_q.oe;
    assign pull_low = drv_q.pull;

    pin_sync #(.WIDTH(NUM_LEDS), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_level),
        .dout  (pin_byte)
    );

endmodule

// File: rtl/led_dim_checker.sv
module led_dim_checker #(
    parameter int unsigned NUM_LEDS = 8,
    parameter int unsigned CNT_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM_LEDS-1:0]  sel_lo,
    input logic [NUM_LEDS-1:0]  sel_hi,
    input logic [NUM_LEDS-1:0]  pin_level,
    input logic [NUM_LEDS-1:0]  drive_en,
    input logic [NUM_LEDS-1:0]  pull_low,
    input logic [NUM_LEDS-1:0]  pin_byte,
    input logic [1:0]           dim_on,
    input logic [1:0]           wrap_ev,
    input logic [1:0][CNT_W-1:0] pwm_cur
);

    logic [2*NUM_LEDS-1:0] sel_all;
    logic [1:0]            since_rst;

    assign sel_all = {sel_hi, sel_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 1'b1;
    end

    // R8: two-stage synchronizer latency
    a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> (pin_byte == $past(pin_level, 2)));

    // R11: no tick, waveform state holds
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dim_on));

    for (genvar c = 0; c < 2; c++) begin : g_chk_chan
        // R3: zero duty never lights
        a_r3_zero_duty_dark: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_cur[c] == '0) |-> !dim_on[c]);
        // R4: working duty only changes at a wrap
        a_r4_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !wrap_ev[c] |=> $stable(pwm_cur[c]));
    end

    for (genvar n = 0; n < NUM_LEDS; n++) begin : g_chk_led
        // R5, R7: released pin
        a_r5_off_released: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_all[2*n +: 2] == 2'b00) |=> (!drive_en[n] && !pull_low[n]));
        // R5, R7: steadily on
        a_r5_on_pulled: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_all[2*n +: 2] == 2'b01) |=> (drive_en[n] && pull_low[n]));
        // R2, R5: follows waveform 0
        a_r2_follow_dim0: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_all[2*n +: 2] == 2'b10) |=> (drive_en[n] && (pull_low[n] == $past(dim_on[0]))));
        // R9, R5: follows waveform 1
        a_r9_follow_dim1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_all[2*n +: 2] == 2'b11) |=> (drive_en[n] && (pull_low[n] == $past(dim_on[1]))));
    end

endmodule

bind led_dim_engine led_dim_checker #(.NUM_LEDS(NUM_LEDS), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .pin_level (pin_level),
    .drive_en  (drive_en),
    .pull_low  (pull_low),
    .pin_byte  (pin_byte),
    .dim_on    (dim_on),
    .wrap_ev   (wrap_ev),
    .pwm_cur   (pwm_cur)
);

// File: tb/test_led_dim_engine.sv
`timescale 1ns/1ps
module test_led_dim_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] psc0_in = '0, pwm0_in = '0, psc1_in = '0, pwm1_in = '0;
    logic [7:0] sel_lo = '0, sel_hi = '0, pin_level = '0;
    logic [7:0] drive_en, pull_low, pin_byte;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // bench model state
    logic [7:0] m_pre [2];
    logic [7:0] m_phase [2];
    logic [7:0] m_psc [2];
    logic [7:0] m_pwm [2];
    logic [7:0] m_s1;
    logic [7:0] e_oe, e_pull, e_pin;

    always #2.5 clk = ~clk;

    led_dim_engine i_led_dim_engine (
        .clk, .rst_n, .tick, .psc0_in, .pwm0_in, .psc1_in, .pwm1_in,
        .sel_lo, .sel_hi, .pin_level, .drive_en, .pull_low, .pin_byte
    );

    task automatic check8(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
        end
    endtask

    function automatic logic wave_on(input int c);
        return m_phase[c] < m_pwm[c];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_pre[c] = 8'h00; m_phase[c] = 8'h00; m_psc[c] = 8'h00; m_pwm[c] = 8'h80;
        end
        m_s1 = '0;
    endtask

    // one clock: predict, advance model, compare after the edge
    task automatic step();
        logic [15:0] s;
        logic [7:0] pv [2];
        logic [7:0] dv [2];
        s = {sel_hi, sel_lo};
        pv[0] = psc0_in; pv[1] = psc1_in;
        dv[0] = pwm0_in; dv[1] = pwm1_in;
        for (int n = 0; n < 8; n++) begin
            logic [1:0] md;
            md = s[2*n +: 2];
            e_oe[n]   = (md != 2'b00);
            e_pull[n] = (md == 2'b01) || (md == 2'b10 && wave_on(0)) || (md == 2'b11 && wave_on(1));
        end
        e_pin = m_s1;
        m_s1  = pin_level;
        if (tick) begin
            for (int c = 0; c < 2; c++) begin
                if (m_pre[c] == m_psc[c]) begin
                    m_pre[c] = 8'h00;
                    if (m_phase[c] == 8'hFF) begin
                        m_psc[c] = pv[c];
                        m_pwm[c] = dv[c];
                    end
                    m_phase[c] = m_phase[c] + 8'h01;
                end else begin
                    m_pre[c] = m_pre[c] + 8'h01;
                end
            end
        end
        @(negedge clk);
        check8(tag, "drive_en", drive_en, e_oe);
        check8(tag, "pull_low", pull_low, e_pull);
        check8("R8", "pin_byte", pin_byte, e_pin);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        model_reset();
        pin_level = 8'hA5; sel_lo = 8'hFF; sel_hi = 8'h55;
        repeat (3) @(negedge clk);
        // R1: reset state holds regardless of inputs
        check8("R1", "drive_en", drive_en, 8'h00);
        check8("R1", "pull_low", pull_low, 8'h00);
        check8("R1", "pin_byte", pin_byte, 8'h00);
        m_s1 = 8'h00;
        rst_n = 1'b1;

        // R10: first period governed by default working values
        tag = "R10";
        sel_lo = 8'hAA; sel_hi = 8'hFF;
        psc0_in = 8'd2; pwm0_in = 8'h10; psc1_in = 8'd1; pwm1_in = 8'hF0;
        tick = 1'b1;
        repeat (600) step();

        // R6: byte placement of mode fields
        tag = "R6";
        for (int k = 0; k < 300; k++) begin
            sel_lo = 8'h1B; sel_hi = 8'hE4;
            tick = ($urandom % 2) == 0;
            pin_level = 8'($urandom);
            step();
        end

        // R3: zero duty against full duty
        tag = "R3";
        psc0_in = 8'd0; pwm0_in = 8'h00; psc1_in = 8'd0; pwm1_in = 8'hFF;
        sel_lo = 8'hAA; sel_hi = 8'hFF; tick = 1'b1;
        repeat (1200) step();

        // R4: duty and prescaler inputs change every cycle
        tag = "R4";
        for (int k = 0; k < 3000; k++) begin
            psc0_in = 8'($urandom % 3); psc1_in = 8'($urandom % 4);
            pwm0_in = 8'($urandom); pwm1_in = 8'($urandom);
            tick = 1'b1;
            step();
        end

        // R11: ticks absent, phase must hold
        tag = "R11";
        tick = 1'b0;
        for (int k = 0; k < 400; k++) begin
            pwm0_in = 8'($urandom); psc0_in = 8'($urandom);
            step();
        end

        // R9: unequal rates on the two waveforms
        tag = "R9";
        psc0_in = 8'd0; pwm0_in = 8'h40; psc1_in = 8'd5; pwm1_in = 8'hC0;
        sel_lo = 8'hAA; sel_hi = 8'hFF; tick = 1'b1;
        repeat (4000) step();

        // R7: modes toggled every cycle, registered latency
        tag = "R7";
        for (int k = 0; k < 500; k++) begin
            sel_lo = (k % 2 == 0) ? 8'h55 : 8'h00;
            sel_hi = (k % 3 == 0) ? 8'hAA : 8'h55;
            tick = ($urandom % 3) == 0;
            step();
        end

        // R5, R2: fully random operation
        tag = "R5";
        for (int k = 0; k < 20000; k++) begin
            if (k == 10000) tag = "R2";
            sel_lo = 8'($urandom); sel_hi = 8'($urandom);
            if (($urandom % 64) == 0) begin
                psc0_in = 8'($urandom % 4); psc1_in = 8'($urandom % 4);
                pwm0_in = 8'($urandom); pwm1_in = 8'($urandom);
            end
            tick = ($urandom % 4) != 0;
            pin_level = 8'($urandom);
            step();
        end

        // R2: duty boundary values 0x01 and 0x80
        tag = "R2";
        sel_lo = 8'hAA; sel_hi = 8'hFF; tick = 1'b1;
        psc0_in = 8'd0; pwm0_in = 8'h01; psc1_in = 8'd0; pwm1_in = 8'h80;
        repeat (1100) step();

        finish_run();
    end

endmodule